// File: doc/BRIEF.md
# Interrupt Priority Threshold and Keyed System-Reset Register Slice

This block is a small register slice that sits beside an interrupt controller. It shows the pending state of a group of seven interrupts to software. It holds a two-bit priority threshold that filters which pending interrupts go forward for service. It also decodes a configuration word whose system-reset request only takes effect when a security key sits in the upper half of the same write.

Software reaches the block over a plain 32-bit bus with a select, a write strobe, an address and data. Reads are combinational from the addressed register. For each of the seven interrupts, the block takes a pending bit and a two-bit priority. It drives a mask of eligible requests and a single request line to the core side. An accepted reset command produces a reset pulse one clock long.

Top module: `irq_thr_slice`

## Requirements
- R1: A read at offset 0x24 returns the seven pending inputs in bits [6:0], with interrupt 32 in bit 0; bits [31:7] read as zero.
- R2: A write at offset 0x40 stores data bits [7:6] as the threshold. A read at 0x40 returns the threshold in bits [7:6], and every other bit reads as zero whatever was written there.
- R3: While the stored threshold is zero, the eligible mask equals the pending inputs.
- R4: While the threshold is nonzero, interrupt i is eligible only when it is pending and its priority field prio[2i+1:2i] is not below the threshold. A lower value is held back.
- R5: The request output is high exactly when at least one bit of the eligible mask is high.
- R6: A write at offset 0x48 with data bit 7 set and 0xBEEF in data bits [31:16] drives the system-reset output high for one clock cycle, starting after the clock edge that takes the write. It falls on the next edge even if the same command is repeated in the next cycle. The same key with bit 7 clear gives no pulse.
- R7: A write at 0x48 whose key field holds 0xFA05, 0xBCAF, zero or any other value is ignored. It gives no pulse and leaves the threshold unchanged.
- R8: A read at offset 0x48 returns zero: the key field is write-only and the reset bit clears itself.
- R9: A read at an unmapped offset returns zero, and a write there changes no state.
- R10: After reset the threshold is zero and the system-reset output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed offset |
| irq_pend | input | 7 | Pending state of interrupts 32 to 38 |
| irq_prio | input | 14 | Two-bit priority per interrupt, interrupt i in [2i+1:2i] |
| irq_elig | output | 7 | Pending interrupts that pass the threshold |
| irq_req | output | 1 | Any eligible interrupt |
| sys_rst_pulse | output | 1 | One-cycle system-reset command |

## Verification
The hardest case to reach is a reset command that looks almost right: the correct key with bit 7 clear, one of the two keys reserved for other controls, or a correct command held on the bus for two cycles in a row. The bench drives each of these as a direct write. It watches the reset output on the cycle after the write and on the cycle after that. It also reads back the threshold, which proves a rejected word left no state behind. Threshold filtering is exercised from a table. The table mixes zero and nonzero thresholds with priorities just below, at and above the threshold, and the expected mask is computed from the rule in the bench.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int IRQ_N   = 7;
    localparam int PRIO_W  = 2;
    localparam int KEY_W   = 16;
    localparam int THR_W   = 8;
    localparam int THR_LSB = THR_W - PRIO_W;
    localparam int RST_BIT = 7;
    localparam int KEY_LSB = DATA_W - KEY_W;

    localparam logic [ADDR_W-1:0] OFS_PEND = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_THR  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h48;

    localparam logic [KEY_W-1:0] KEY_SYSRST = 16'hBEEF;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_THR,
        SEL_CFG
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic [KEY_W-1:0] key;
        logic             rst_req;
    } cfg_wr_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            OFS_PEND: s = SEL_PEND;
            OFS_THR:  s = SEL_THR;
            OFS_CFG:  s = SEL_CFG;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
    import irq_thr_pkg::*;
#(
    parameter int N  = IRQ_N,
    parameter int PW = PRIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N-1:0]      pend,
    output logic [DATA_W-1:0] rdata,
    output logic [PW-1:0]     thr,
    output cfg_wr_t           cfg
);
    localparam int TLSB = THR_W - PW;

    reg_sel_e sel_r;
    logic     wr_thr;

    always_comb begin
        sel_r  = decode_ofs(bus_addr);
        wr_thr = bus_sel && bus_wr && (sel_r == SEL_THR);
    end

    always_ff @(posedge clk) begin
        if (rst)
            thr <= '0;
        else if (wr_thr)
            thr <= bus_wdata[TLSB +: PW];
    end

    always_comb begin
        cfg.wr      = bus_sel && bus_wr && (sel_r == SEL_CFG);
        cfg.key     = bus_wdata[KEY_LSB +: KEY_W];
        cfg.rst_req = bus_wdata[RST_BIT];
    end

    always_comb begin
        rdata = '0;
        unique case (sel_r)
            SEL_PEND: rdata[N-1:0]      = pend;
            SEL_THR:  rdata[TLSB +: PW] = thr;
            default:  rdata             = '0;
        endcase
    end

    AST_THR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr == OFS_THR) |=> $stable(thr)); // R9

endmodule

// File: rtl/irq_key_gate.sv
module irq_key_gate
    import irq_thr_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = KEY_SYSRST
) (
    input  logic    clk,
    input  logic    rst,
    input  cfg_wr_t cfg,
    output logic    pulse
);
    logic fire;

    always_comb fire = cfg.wr && cfg.rst_req && (cfg.key == KEY);

    always_ff @(posedge clk) begin
        if (rst)
            pulse <= 1'b0;
        else
            pulse <= fire && !pulse;
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R6

endmodule

// File: rtl/irq_thr_filter.sv
module irq_thr_filter
    import irq_thr_pkg::*;
#(
    parameter int N  = IRQ_N,
    parameter int PW = PRIO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] thr,
    input  logic [N-1:0]  pend,
    input  logic [N*PW-1:0] prio,
    output logic [N-1:0]  elig,
    output logic          req
);
    logic filt_on;

    always_comb filt_on = (thr != '0);

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [PW-1:0] p;
        always_comb begin
            p       = prio[i*PW +: PW];
            elig[i] = pend[i] && !(filt_on && (p < thr));
        end
    end

    always_comb req = |elig;

    AST_ELIG_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (elig & ~pend) == '0); // R4

endmodule

// File: rtl/irq_thr_slice.sv
module irq_thr_slice
    import irq_thr_pkg::*;
#(
    parameter int N  = IRQ_N,
    parameter int PW = PRIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      irq_pend,
    input  logic [N*PW-1:0]   irq_prio,
    output logic [N-1:0]      irq_elig,
    output logic              irq_req,
    output logic              sys_rst_pulse
);
    logic [PW-1:0] thr;
    cfg_wr_t       cfg;

    irq_bus_regs #(.N(N), .PW(PW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend      (irq_pend),
        .rdata     (bus_rdata),
        .thr       (thr),
        .cfg       (cfg)
    );

    irq_key_gate #(.KEY(KEY_SYSRST)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .pulse (sys_rst_pulse)
    );

    irq_thr_filter #(.N(N), .PW(PW)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .thr  (thr),
        .pend (irq_pend),
        .prio (irq_prio),
        .elig (irq_elig),
        .req  (irq_req)
    );

    AST_THR_OFF: assert property (@(posedge clk) disable iff (rst)
        (thr == '0) |-> (irq_elig == irq_pend)); // R3

    AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_pend != '0)); // R5

    AST_RST_KEYED: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |-> $past(bus_sel && bus_wr && bus_addr == OFS_CFG &&
                                bus_wdata[RST_BIT] &&
                                bus_wdata[KEY_LSB +: KEY_W] == KEY_SYSRST)); // R7

endmodule

// File: tb/sim_irq_thr_slice.sv
module sim_irq_thr_slice;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  irq_pend = '0;
    logic [13:0] irq_prio = '0;
    logic [6:0]  irq_elig;
    logic        irq_req;
    logic        sys_rst_pulse;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_thr_slice u0 (.*);

    // {pend[6:0], prio[13:0], thr[1:0]}
    localparam int NV = 10;
    localparam logic [22:0] VEC [NV] = '{
        {7'h7F, 14'h1B1B, 2'd0},
        {7'h55, 14'h0000, 2'd0},
        {7'h7F, 14'h1B1B, 2'd1},
        {7'h7F, 14'h1B1B, 2'd2},
        {7'h7F, 14'h1B1B, 2'd3},
        {7'h2A, 14'h3FFF, 2'd3},
        {7'h7F, 14'h0000, 2'd1},
        {7'h00, 14'h3FFF, 2'd1},
        {7'h41, 14'h2AA5, 2'd2},
        {7'h3C, 14'h15A6, 2'd2}
    };

    function automatic logic [6:0] model_elig(logic [6:0] p, logic [13:0] pr, logic [1:0] t);
        logic [6:0] e;
        for (int i = 0; i < 7; i++)
            e[i] = p[i] && (t == 0 || pr[2*i +: 2] >= t);
        return e;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic bread(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state
        bread(8'h40, rd); chk("R10 thr", rd, 0);
        chk("R10 pulse", {31'b0, sys_rst_pulse}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [6:0] p; logic [13:0] pr; logic [1:0] t; logic [6:0] e;
            {p, pr, t} = VEC[v];
            bwrite(8'h40, {24'hABCDEF, t, 6'h3F} ^ 32'h0);
            irq_pend = p; irq_prio = pr;
            #1;
            e = model_elig(p, pr, t);
            chk(t == 0 ? "R3 elig" : "R4 elig", {25'b0, irq_elig}, {25'b0, e});
            chk("R5 req", {31'b0, irq_req}, {31'b0, |e});
            bread(8'h24, rd); chk("R1 pend read", rd, {25'b0, p});
            bread(8'h40, rd); chk("R2 thr read", rd, {24'b0, t, 6'b0});
        end

        // set known threshold 2 for state checks
        bwrite(8'h40, 32'h80);
        // R7 rejected keys
        bwrite(8'h48, 32'hFA05_0080); chk("R7 key FA05", {31'b0, sys_rst_pulse}, 0);
        bwrite(8'h48, 32'hBCAF_0080); chk("R7 key BCAF", {31'b0, sys_rst_pulse}, 0);
        bwrite(8'h48, 32'h0000_0080); chk("R7 no key", {31'b0, sys_rst_pulse}, 0);
        bwrite(8'h48, 32'hBEEE_00C0); chk("R7 near key", {31'b0, sys_rst_pulse}, 0);
        bread(8'h40, rd); chk("R7 thr kept", rd, 32'h80);
        // R6 correct key, bit 7 clear
        bwrite(8'h48, 32'hBEEF_007F); chk("R6 bit7 clear", {31'b0, sys_rst_pulse}, 0);
        // R6 accepted command
        bwrite(8'h48, 32'hBEEF_0080); chk("R6 pulse high", {31'b0, sys_rst_pulse}, 1);
        @(negedge clk); chk("R6 pulse low", {31'b0, sys_rst_pulse}, 0);
        // R6 held for two cycles
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 8'h48; bus_wdata = 32'hBEEF_0080;
        @(negedge clk); chk("R6 held c1", {31'b0, sys_rst_pulse}, 1);
        @(negedge clk); bus_sel = 0; bus_wr = 0; bus_wdata = '0;
        chk("R6 held c2", {31'b0, sys_rst_pulse}, 0);
        // R8 config reads zero
        bread(8'h48, rd); chk("R8 cfg read", rd, 0);
        // R9 unmapped
        bwrite(8'h44, 32'hFFFF_FFC0);
        bread(8'h40, rd); chk("R9 write ignored", rd, 32'h80);
        irq_pend = 7'h7F;
        bread(8'h44, rd); chk("R9 read zero", rd, 0);
        bread(8'h28, rd); chk("R9 read zero 28", rd, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule